// File: doc/BRIEF.md
# Multi-Domain Timestamp Tagger

This block turns a monitored data word into a tagged record that is ready to be written into a monitoring FIFO. Each record joins three things: the monitored word, the current event number, and a timestamp taken from one of three time bases. The first base is a global counter that must read the same on every board, so it can be loaded from an external synchronisation input. The second is a local counter that runs freely at full clock rate with no synchronisation, which gives the finest accuracy. The third counts the time since the most recent trigger.

Two build-time parameters, the resolution exponent `RES_BITS` and the field width `TS_W`, set how the timestamp is cut. All three bases count at full clock rate over `CNT_W = RES_BITS + TS_W` bits, and the timestamp field takes counter bits `[CNT_W-1:RES_BITS]`. Each field step therefore lasts 2^RES_BITS clock cycles, which lets the tag match the rate of the signal being watched. A trigger pulse bumps the event number and restarts the since-trigger base on the same edge.

Samples enter on a valid/ready stream and leave as records on a second valid/ready stream in the same cycle. The block adds no buffering. `in_ready_o` follows `out_ready_i` directly, so back-pressure from the FIFO reaches the sample source at once. While a record waits, its timestamp and event number stay frozen at the values seen in the first cycle it was offered. The source must hold `in_valid_i` and `in_data_i` steady until the record is accepted.

Top module: `ts_tagger`

## Requirements
- R1: After reset, all three time bases and the event number read zero, so the first record offered carries timestamp 0 and event number 0.
- R2: The local base advances by one on every clock edge and wraps. The timestamp field of a record holds base bits `[CNT_W-1:RES_BITS]`.
- R3: When `gt_load_i` is high on an edge, the global base takes `gt_value_i`. On every other edge it advances by one and wraps.
- R4: A trigger edge sets the since-trigger base to zero. Without a trigger, it advances by one and then stays at all ones instead of wrapping.
- R5: The event number rises by one on each trigger edge, on the same edge that clears the since-trigger base, and wraps at `2^EVT_W`.
- R6: `dom_sel_i` picks the timestamp source: 0 picks global, 1 picks local, 2 picks since-trigger, and 3 gives a timestamp of zero.
- R7: The record is `{event[EVT_W-1:0], timestamp[TS_W-1:0], data[DATA_W-1:0]}`, with the event number in the top bits and the data in the bottom bits. `out_valid_o` equals `in_valid_i` in the same cycle.
- R8: `in_ready_o` equals `out_ready_i`. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` stays stable. Its timestamp and event fields keep the values from the first cycle of the stall.
- R9: The data field of the record equals `in_data_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger pulse, one cycle per trigger |
| gt_load_i | input | 1 | Load strobe for the global time base |
| gt_value_i | input | CNT_W | Value written into the global time base |
| dom_sel_i | input | 2 | Time-domain select |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Sample accepted when high with in_valid_i |
| in_data_i | input | DATA_W | Monitored data word |
| out_valid_o | output | 1 | Record offered |
| out_ready_i | input | 1 | Downstream FIFO can take the record |
| out_data_o | output | EVT_W+TS_W+DATA_W | Packed record |

## Verification
A wrong time-base count shows in the timestamp field of the very next record that selects that domain. If the error sits below bit `RES_BITS`, it stays hidden until the next carry, which can take up to 2^RES_BITS cycles. An event counter that misses or double-counts a trigger shows in every later record, and a since-trigger base that fails to clear or that wraps shows on the first record after the trigger or after saturation. A broken stall register shows as a timestamp that moves in the second cycle of any back-pressured record.

// File: rtl/ts_tag_pkg.sv
package ts_tag_pkg;

  typedef enum logic [1:0] {
    DOM_GLOBAL = 2'd0,
    DOM_LOCAL  = 2'd1,
    DOM_TRIG   = 2'd2,
    DOM_NONE   = 2'd3
  } dom_e;

endpackage

// File: rtl/ts_counter.sv
// Full-rate counter with optional parallel load and a choice of wrap or
// saturate behaviour, selected at build time.
module ts_counter #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b0,
  parameter bit HAS_LOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] step_val;

  generate
    if (SATURATE) begin : g_sat
      always_comb step_val = (cnt_q == MAX_VAL) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      always_comb step_val = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (HAS_LOAD && load_i) begin
      cnt_q <= load_val_i;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= step_val;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ts_domain_mux.sv
// Picks one time base and slices out the timestamp field.
module ts_domain_mux
  import ts_tag_pkg::*;
#(
  parameter int RES_BITS = 2,
  parameter int TS_W     = 12,
  localparam int CNT_W   = RES_BITS + TS_W
) (
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] glb_i,
  input  logic [CNT_W-1:0] loc_i,
  input  logic [CNT_W-1:0] trg_i,
  output logic [TS_W-1:0]  ts_o
);

  logic [CNT_W-1:0] picked;

  always_comb begin
    unique case (dom_e'(sel_i))
      DOM_GLOBAL: picked = glb_i;
      DOM_LOCAL:  picked = loc_i;
      DOM_TRIG:   picked = trg_i;
      default:    picked = '0;
    endcase
  end

  assign ts_o = picked[CNT_W-1:RES_BITS];

endmodule

// File: rtl/ts_stall_hold.sv
// Freezes the tag fields of a record while the downstream stalls it.
module ts_stall_hold #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic [TAG_W-1:0] live_tag_i,
  output logic [TAG_W-1:0] tag_o
);

  logic             stall_q;
  logic [TAG_W-1:0] held_q;
  logic             stalling;

  assign stalling = valid_i && !ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      held_q  <= '0;
    end else begin
      stall_q <= stalling;
      if (stalling && !stall_q) begin
        held_q <= live_tag_i;
      end
    end
  end

  assign tag_o = stall_q ? held_q : live_tag_i;

endmodule

// File: rtl/ts_tagger.sv
module ts_tagger
  import ts_tag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TS_W     = 12,
  parameter int RES_BITS = 2,
  parameter int EVT_W    = 8,
  localparam int CNT_W   = RES_BITS + TS_W,
  localparam int TAG_W   = EVT_W + TS_W,
  localparam int REC_W   = TAG_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              gt_load_i,
  input  logic [CNT_W-1:0]  gt_value_i,
  input  logic [1:0]        dom_sel_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [REC_W-1:0]  out_data_o
);

  logic [CNT_W-1:0] glb_cnt;
  logic [CNT_W-1:0] loc_cnt;
  logic [CNT_W-1:0] trg_cnt;
  logic [EVT_W-1:0] evt_cnt;
  logic [TS_W-1:0]  ts_live;
  logic [TAG_W-1:0] tag_out;

  ts_counter #(.W(CNT_W), .SATURATE(1'b0), .HAS_LOAD(1'b1)) u_glb (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .clr_i(1'b0),
    .load_i(gt_load_i), .load_val_i(gt_value_i), .cnt_o(glb_cnt)
  );

  ts_counter #(.W(CNT_W), .SATURATE(1'b0), .HAS_LOAD(1'b0)) u_loc (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .clr_i(1'b0),
    .load_i(1'b0), .load_val_i('0), .cnt_o(loc_cnt)
  );

  ts_counter #(.W(CNT_W), .SATURATE(1'b1), .HAS_LOAD(1'b0)) u_trg (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .clr_i(trig_i),
    .load_i(1'b0), .load_val_i('0), .cnt_o(trg_cnt)
  );

  ts_counter #(.W(EVT_W), .SATURATE(1'b0), .HAS_LOAD(1'b0)) u_evt (
    .clk(clk), .rst_n(rst_n), .en_i(trig_i), .clr_i(1'b0),
    .load_i(1'b0), .load_val_i('0), .cnt_o(evt_cnt)
  );

  ts_domain_mux #(.RES_BITS(RES_BITS), .TS_W(TS_W)) u_mux (
    .sel_i(dom_sel_i), .glb_i(glb_cnt), .loc_i(loc_cnt), .trg_i(trg_cnt),
    .ts_o(ts_live)
  );

  ts_stall_hold #(.TAG_W(TAG_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .valid_i(in_valid_i), .ready_i(out_ready_i),
    .live_tag_i({evt_cnt, ts_live}), .tag_o(tag_out)
  );

  assign out_valid_o = in_valid_i;
  assign in_ready_o  = out_ready_i;
  assign out_data_o  = {tag_out, in_data_i};

endmodule

// File: rtl/ts_tagger_chk.sv
module ts_tagger_chk #(
  parameter int DATA_W   = 16,
  parameter int TS_W     = 12,
  parameter int RES_BITS = 2,
  parameter int EVT_W    = 8,
  localparam int CNT_W   = RES_BITS + TS_W,
  localparam int REC_W   = EVT_W + TS_W + DATA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             gt_load_i,
  input logic [CNT_W-1:0] gt_value_i,
  input logic [1:0]       dom_sel_i,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [REC_W-1:0] out_data_o,
  input logic [CNT_W-1:0] glb_cnt,
  input logic [CNT_W-1:0] loc_cnt,
  input logic [CNT_W-1:0] trg_cnt,
  input logic [EVT_W-1:0] evt_cnt
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_local_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> loc_cnt == CNT_W'($past(loc_cnt) + 1'b1));

  p_global_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gt_load_i) |=> glb_cnt == $past(gt_value_i));

  p_trig_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_i) |=> trg_cnt == '0);

  p_trig_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trg_cnt == MAX_CNT && !trig_i) |=> trg_cnt == MAX_CNT);

  p_event_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_i) |=> evt_cnt == EVT_W'($past(evt_cnt) + 1'b1));

  p_none_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid_i && dom_sel_i == 2'd3 && !$past(in_valid_i && !out_ready_i))
      |-> out_data_o[DATA_W +: TS_W] == '0);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid_o && !out_ready_i) |=> (!out_valid_o || $stable(out_data_o)));

endmodule

bind ts_tagger ts_tagger_chk #(
  .DATA_W(DATA_W), .TS_W(TS_W), .RES_BITS(RES_BITS), .EVT_W(EVT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .gt_load_i(gt_load_i),
  .gt_value_i(gt_value_i), .dom_sel_i(dom_sel_i), .in_valid_i(in_valid_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .glb_cnt(glb_cnt), .loc_cnt(loc_cnt), .trg_cnt(trg_cnt), .evt_cnt(evt_cnt)
);

// File: tb/ts_tagger_bench.sv
module ts_tagger_bench;

  localparam int DATA_W   = 16;
  localparam int TS_W     = 6;
  localparam int RES_BITS = 2;
  localparam int EVT_W    = 4;
  localparam int CNT_W    = RES_BITS + TS_W;
  localparam int REC_W    = EVT_W + TS_W + DATA_W;
  localparam int NVEC     = 10;

  // vector: {sel[2], trig, gload, gval[8], data[16]}
  localparam logic [27:0] VEC [0:NVEC-1] = '{
    {2'd1, 1'b0, 1'b0, 8'h00, 16'hA5A5},
    {2'd0, 1'b0, 1'b0, 8'h00, 16'h0001},
    {2'd0, 1'b0, 1'b1, 8'hF0, 16'h1234},
    {2'd0, 1'b0, 1'b0, 8'h00, 16'hFFFF},
    {2'd2, 1'b1, 1'b0, 8'h00, 16'h5A5A},
    {2'd2, 1'b0, 1'b0, 8'h00, 16'h0F0F},
    {2'd1, 1'b1, 1'b1, 8'h3C, 16'hBEEF},
    {2'd0, 1'b0, 1'b0, 8'h00, 16'h0000},
    {2'd3, 1'b0, 1'b0, 8'h00, 16'hC0DE},
    {2'd2, 1'b0, 1'b0, 8'h00, 16'h7777}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig = 1'b0, gload = 1'b0;
  logic [CNT_W-1:0]  gval = '0;
  logic [1:0]        sel = '0;
  logic              in_valid = 1'b0, out_ready = 1'b0;
  logic              in_ready, out_valid;
  logic [DATA_W-1:0] in_data = '0;
  logic [REC_W-1:0]  out_data;

  always #5 clk = ~clk;

  ts_tagger #(.DATA_W(DATA_W), .TS_W(TS_W), .RES_BITS(RES_BITS), .EVT_W(EVT_W)) u_ts_tagger (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .gt_load_i(gload), .gt_value_i(gval),
    .dom_sel_i(sel), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [CNT_W-1:0] m_glb, m_loc, m_trg;
  logic [EVT_W-1:0] m_evt, h_evt;
  logic [TS_W-1:0]  h_ts;
  bit               m_stall;

  task automatic model_reset();
    m_glb = '0; m_loc = '0; m_trg = '0; m_evt = '0;
    h_evt = '0; h_ts = '0; m_stall = 1'b0;
  endtask

  function automatic logic [TS_W-1:0] exp_ts(input logic [1:0] s);
    logic [CNT_W-1:0] v;
    case (s)
      2'd0: v = m_glb;
      2'd1: v = m_loc;
      2'd2: v = m_trg;
      default: v = '0;
    endcase
    return v[CNT_W-1:RES_BITS];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic tr, input logic gl,
                      input logic [CNT_W-1:0] gv, input logic [DATA_W-1:0] d,
                      input logic vld, input logic rdy, input string tag);
    logic [TS_W-1:0]  lts;
    logic [REC_W-1:0] exp;
    sel = s; trig = tr; gload = gl; gval = gv; in_data = d;
    in_valid = vld; out_ready = rdy;
    #1;
    lts = exp_ts(s);
    exp = m_stall ? {h_evt, h_ts, d} : {m_evt, lts, d};
    chk(out_valid == vld, {tag, " R7 valid"}, 64'(out_valid), 64'(vld));
    chk(in_ready == rdy, {tag, " R8 ready"}, 64'(in_ready), 64'(rdy));
    if (vld) chk(out_data == exp, {tag, " record"}, 64'(out_data), 64'(exp));
    @(posedge clk);
    if (vld && !rdy) begin
      if (!m_stall) begin h_evt = m_evt; h_ts = lts; end
      m_stall = 1'b1;
    end else begin
      m_stall = 1'b0;
    end
    m_loc = m_loc + 1'b1;
    m_glb = gl ? gv : m_glb + 1'b1;
    if (tr) begin
      m_trg = '0;
      m_evt = m_evt + 1'b1;
    end else if (m_trg != {CNT_W{1'b1}}) begin
      m_trg = m_trg + 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig = 1'b0; gload = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1: zeroed state on first record
    step(2'd1, 1'b0, 1'b0, '0, 16'h1234, 1'b1, 1'b1, "R1 reset local");
    step(2'd2, 1'b0, 1'b0, '0, 16'h4321, 1'b1, 1'b1, "R1 reset trig");

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][27:26], VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0],
           1'b1, 1'b1, "R2 R3 R5 R6 R9 table");
    end

    // R2: several field steps on local base
    for (int i = 0; i < 9; i++)
      step(2'd1, 1'b0, 1'b0, '0, 16'(i), 1'b1, 1'b1, "R2 local field");

    // R5: event wraps after 2^EVT_W triggers
    for (int i = 0; i < 17; i++)
      step(2'd2, 1'b1, 1'b0, '0, 16'hE000 + 16'(i), 1'b1, 1'b1, "R5 event wrap");

    // R4: saturation of since-trigger base
    for (int i = 0; i < 300; i++)
      step(2'd2, 1'b0, 1'b0, '0, 16'h5000, 1'b1, 1'b1, "R4 saturate");
    step(2'd2, 1'b1, 1'b0, '0, 16'h5001, 1'b1, 1'b1, "R4 trigger after saturation");
    step(2'd2, 1'b0, 1'b0, '0, 16'h5002, 1'b1, 1'b1, "R4 clear");

    // R6: select 3 yields zero timestamp
    step(2'd3, 1'b0, 1'b0, '0, 16'h3333, 1'b1, 1'b1, "R6 none");

    // R3: load at wrap edge of global base
    step(2'd0, 1'b0, 1'b1, 8'hFF, 16'h0A0A, 1'b1, 1'b1, "R3 load max");
    step(2'd0, 1'b0, 1'b0, '0, 16'h0B0B, 1'b1, 1'b1, "R3 after load");
    step(2'd0, 1'b0, 1'b0, '0, 16'h0C0C, 1'b1, 1'b1, "R3 wrap");

    // R8: stall holds tag fields, even across trigger and select change
    step(2'd1, 1'b0, 1'b0, '0, 16'h8888, 1'b1, 1'b0, "R8 stall first");
    for (int i = 0; i < 6; i++)
      step(2'd1, 1'b0, 1'b0, '0, 16'h8888, 1'b1, 1'b0, "R8 stall hold");
    step(2'd1, 1'b1, 1'b0, '0, 16'h8888, 1'b1, 1'b0, "R8 stall with trigger");
    step(2'd1, 1'b0, 1'b0, '0, 16'h8888, 1'b1, 1'b1, "R8 accept");
    step(2'd1, 1'b0, 1'b0, '0, 16'h9999, 1'b1, 1'b1, "R8 live again");

    // R7: no sample, no record; ready still follows downstream
    step(2'd0, 1'b0, 1'b0, '0, 16'h0000, 1'b0, 1'b1, "R7 idle");
    step(2'd0, 1'b0, 1'b0, '0, 16'h0000, 1'b0, 1'b0, "R7 idle stalled");

    // R1: mid-run reset returns to zero
    do_reset();
    step(2'd0, 1'b0, 1'b0, '0, 16'hF00D, 1'b1, 1'b1, "R1 second reset");
    step(2'd1, 1'b0, 1'b0, '0, 16'hF00E, 1'b1, 1'b1, "R1 second reset local");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule